// File: doc/BRIEF.md
# Cached DRAM Command Decoder

This block is the device-side command decoder of a cached DRAM module. Each control input arrives asynchronously and active-low. The block brings every input into the system clock domain with a two-flop synchronizer and watches the synchronized row strobe. On each falling edge of that strobe it reads the operation pins, the chip select and the column strobe. From these it classifies the access as a read, a write, a counter-driven refresh, a self-refresh entry or an illegal command.

For the cycle after classification, the block presents a 3-bit operation code and an illegal flag. It holds the row address that was latched for the array. It keeps an internal refresh row counter that supplies the row on refresh cycles. A self-refresh state, once entered, stays set until the row strobe returns high. A column address latch passes the address through while the column strobe is high and freezes it when the strobe is low. The two low column bits pick the interleaved word. A data-write strobe is also produced.

Top module: `cdram_cmd_dec`

## Requirements
- R1: With `rfsh_n_i` low at a row strobe fall, the operation code is refresh (3). This holds whatever the chip select and column strobe levels are. `row_addr_o` takes the current refresh counter value, and the counter then advances by one, wrapping from 2047 to 0.
- R2: With `rfsh_n_i` high, `cs_n_i` low and `col_n_i` high at a row strobe fall, `wr_i` high gives write (2) and `wr_i` low gives read (1). `row_addr_o` latches `addr_i`.
- R3: Self-refresh entry occurs at a row strobe fall when `cs_n_i`, `wr_i`, `rfsh_n_i` and `we_n_i` are all high and `col_n_i` is low. It gives code 4 and sets `self_rfsh_o`. `self_rfsh_o` stays high until the synchronized row strobe is seen high, and clears on the clock edge after that.
- R4: While the synchronized `col_n_i` is high, `col_addr_o` follows the synchronized `addr_i`. While it is low, `col_addr_o` holds the last value it had while the strobe was high.
- R5: A non-refresh, non-self-refresh fall with `col_n_i` low gives illegal (7), with `illegal_o` high.
- R6: A read, write or plain row-strobe fall with `cs_n_i` high (not a refresh, not self-refresh entry) gives illegal (7). It changes neither `row_addr_o` nor the refresh counter.
- R7: `data_wr_o` is high exactly when the synchronized `col_n_i` and `we_n_i` are both low.
- R8: `word_sel_o` equals bits [1:0] of `col_addr_o`.
- R9: Inputs pass through two synchronizer flops. The operation code appears on the third rising clock edge after the row strobe falls and lasts exactly one clock; otherwise it is idle (0). After reset: `op_o` = 0, `illegal_o` = 0, `self_rfsh_o` = 0, `row_addr_o` = 0, refresh counter = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_n_i | input | 1 | Row strobe, active low |
| col_n_i | input | 1 | Column address latch strobe, active low |
| wr_i | input | 1 | Write (1) / read (0) select |
| rfsh_n_i | input | 1 | Refresh request, active low |
| we_n_i | input | 1 | Write enable, active low |
| cs_n_i | input | 1 | Chip select, active low |
| addr_i | input | 11 | Multiplexed row/column address |
| op_o | output | 3 | Operation: 0 idle, 1 read, 2 write, 3 refresh, 4 self-refresh, 7 illegal |
| illegal_o | output | 1 | Illegal command flag, same cycle as op_o |
| row_addr_o | output | 11 | Latched row address |
| col_addr_o | output | 11 | Column latch output |
| word_sel_o | output | 2 | Interleaved word select |
| self_rfsh_o | output | 1 | Self-refresh state |
| data_wr_o | output | 1 | Data latch write strobe |

## Verification
A table of strobe patterns exercises the decoder. Reads and writes with the chip selected separate the two directions. Refresh cycles are issued with chip select and column strobe both active and inactive, which shows the refresh exemption. Unselected accesses and low column strobe accesses must decode as illegal. Two near-identical patterns matter most: the self-refresh pattern, and the same pattern with write enable low. The second must decode as illegal, which shows that every pin takes part in self-refresh detection. Refresh rows seen after illegal commands show that the counter was not disturbed. A run of refreshes past 2047 covers the wrap.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_RFSH  = 3'd3,
    OP_SELF  = 3'd4,
    OP_ILL   = 3'd7
  } op_e;

  typedef struct packed {
    logic row_n;
    logic col_n;
    logic wr;
    logic rfsh_n;
    logic we_n;
    logic cs_n;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/cdram_sync.sv
module cdram_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdram_op_decode.sv
module cdram_op_decode
  import cdram_pkg::*;
(
  input  logic col_n_i,
  input  logic wr_i,
  input  logic rfsh_n_i,
  input  logic we_n_i,
  input  logic cs_n_i,
  output op_e  op_o
);
  // refresh pin wins; self-refresh needs cs high so it precedes the unselected check
  always_comb begin
    if (!rfsh_n_i)                                op_o = OP_RFSH;
    else if (cs_n_i && wr_i && we_n_i && !col_n_i) op_o = OP_SELF;
    else if (cs_n_i || !col_n_i)                  op_o = OP_ILL;
    else if (wr_i)                                op_o = OP_WRITE;
    else                                          op_o = OP_READ;
  end
endmodule

// File: rtl/cdram_rfsh_ctr.sv
module cdram_rfsh_ctr #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] cnt_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6
  ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_o));
endmodule

// File: rtl/cdram_col_latch.sv
module cdram_col_latch #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_q <= '0;
    else if (stb_i) held_q <= addr_i;
  end

  // transparent while strobe high
  assign addr_o = stb_i ? addr_i : held_q;

  // R4
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && $past(!stb_i)) |-> $stable(addr_o));
endmodule

// File: rtl/cdram_cmd_dec.sv
module cdram_cmd_dec
  import cdram_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_n_i,
  input  logic          col_n_i,
  input  logic          wr_i,
  input  logic          rfsh_n_i,
  input  logic          we_n_i,
  input  logic          cs_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [2:0]    op_o,
  output logic          illegal_o,
  output logic [AW-1:0] row_addr_o,
  output logic [AW-1:0] col_addr_o,
  output logic [1:0]    word_sel_o,
  output logic          self_rfsh_o,
  output logic          data_wr_o
);
  ctl_t          ctl_raw, ctl_s;
  logic [AW-1:0] addr_s;
  logic          row_d_q, row_fall, row_rise;
  op_e           dec_op, op_q;
  logic          illegal_q, self_q;
  logic [AW-1:0] row_q, rfsh_cnt;
  logic          rfsh_adv;

  assign ctl_raw = '{row_n: row_n_i, col_n: col_n_i, wr: wr_i,
                     rfsh_n: rfsh_n_i, we_n: we_n_i, cs_n: cs_n_i};

  cdram_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_raw), .q_o(ctl_s));

  cdram_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(addr_i), .q_o(addr_s));

  cdram_op_decode u_dec (
    .col_n_i(ctl_s.col_n), .wr_i(ctl_s.wr), .rfsh_n_i(ctl_s.rfsh_n),
    .we_n_i(ctl_s.we_n), .cs_n_i(ctl_s.cs_n), .op_o(dec_op));

  assign row_fall = row_d_q & ~ctl_s.row_n;
  assign row_rise = ~row_d_q & ctl_s.row_n;
  assign rfsh_adv = row_fall && (dec_op == OP_RFSH);

  cdram_rfsh_ctr #(.AW(AW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rfsh_adv), .cnt_o(rfsh_cnt));

  cdram_col_latch #(.AW(AW)) u_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(ctl_s.col_n),
    .addr_i(addr_s), .addr_o(col_addr_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_d_q   <= 1'b1;
      op_q      <= OP_IDLE;
      illegal_q <= 1'b0;
      self_q    <= 1'b0;
      row_q     <= '0;
    end else begin
      row_d_q <= ctl_s.row_n;
      if (row_fall) begin
        op_q      <= dec_op;
        illegal_q <= (dec_op == OP_ILL);
        if (dec_op == OP_READ || dec_op == OP_WRITE) row_q <= addr_s;
        else if (dec_op == OP_RFSH)                  row_q <= rfsh_cnt;
      end else begin
        op_q      <= OP_IDLE;
        illegal_q <= 1'b0;
      end
      if (row_fall && dec_op == OP_SELF) self_q <= 1'b1;
      else if (row_rise)                 self_q <= 1'b0;
    end
  end

  assign op_o        = op_q;
  assign illegal_o   = illegal_q;
  assign row_addr_o  = row_q;
  assign self_rfsh_o = self_q;
  assign word_sel_o  = col_addr_o[1:0];
  assign data_wr_o   = ~ctl_s.col_n & ~ctl_s.we_n;

  // R9
  op_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o != OP_IDLE) |=> (op_o == OP_IDLE));

  // R1
  rfsh_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_RFSH) |-> (rfsh_cnt == AW'(row_addr_o + 1'b1)));

  // R3
  self_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_rfsh_o) |-> (op_o == OP_SELF));

  // R6
  ill_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(row_addr_o));
endmodule

// File: tb/sim_cdram_cmd_dec.sv
module sim_cdram_cmd_dec;
  localparam int AW = 11;
  localparam int NV = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic row_n_i = 1'b1, col_n_i = 1'b1, wr_i = 1'b1, rfsh_n_i = 1'b1;
  logic we_n_i = 1'b1, cs_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [2:0] op_o;
  logic illegal_o, self_rfsh_o, data_wr_o;
  logic [AW-1:0] row_addr_o, col_addr_o;
  logic [1:0] word_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cdram_cmd_dec u0 (.*);

  // {rfsh_n, wr, cs_n, we_n, col_n, addr, expected op}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h123, 3'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 11'h7ff, 3'd2},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h055, 3'd3},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 11'h2aa, 3'd3},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h011, 3'd7},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'h022, 3'd7},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'h033, 3'd4},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 11'h044, 3'd7},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'h066, 3'd3},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h400, 3'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // set pins, let them settle, drop row strobe, stop just after the op cycle
  task automatic issue(input logic rf, input logic w, input logic cs, input logic we,
                       input logic cl, input logic [AW-1:0] a);
    @(negedge clk_i);
    rfsh_n_i = rf; wr_i = w; cs_n_i = cs; we_n_i = we; col_n_i = cl; addr_i = a;
    row_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    row_n_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic release_row();
    row_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    int exp_row;
    int exp_cnt;
    exp_row = 0;
    exp_cnt = 0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset op", 32'(op_o), 0);
    chk("R9 reset illegal", 32'(illegal_o), 0);
    chk("R9 reset self", 32'(self_rfsh_o), 0);
    chk("R9 reset row", 32'(row_addr_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      logic [2:0] eop;
      v = VEC[i];
      eop = v[2:0];
      issue(v[18], v[17], v[16], v[15], v[14], v[13:3]);
      if (eop == 3'd1 || eop == 3'd2) exp_row = int'(v[13:3]);
      if (eop == 3'd3) begin
        exp_row = exp_cnt;
        exp_cnt = (exp_cnt + 1) % 2048;
      end
      // R1 R2 R5 R6 decode, R3 self entry
      chk($sformatf("R2/R1/R5/R6/R3 op vec%0d", i), 32'(op_o), 32'(eop));
      chk($sformatf("R5 illegal flag vec%0d", i), 32'(illegal_o), 32'(eop == 3'd7));
      chk($sformatf("R1/R2/R6 row vec%0d", i), 32'(row_addr_o), 32'(exp_row));
      chk($sformatf("R3 self set vec%0d", i), 32'(self_rfsh_o), 32'(eop == 3'd4));
      @(negedge clk_i);
      chk($sformatf("R9 op one clock vec%0d", i), 32'(op_o), 0);
      row_n_i = 1'b1;
      repeat (2) @(negedge clk_i);
      chk($sformatf("R3 self held vec%0d", i), 32'(self_rfsh_o), 32'(eop == 3'd4));
      @(negedge clk_i);
      chk($sformatf("R3 self cleared vec%0d", i), 32'(self_rfsh_o), 0);
    end

    // R1 counter wrap
    for (int k = exp_cnt; k <= 2048; k++) begin
      issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'h0);
      if (k >= 2047) chk($sformatf("R1 wrap row k=%0d", k), 32'(row_addr_o), 32'(k % 2048));
      release_row();
    end

    // R4 R8 column latch
    @(negedge clk_i);
    col_n_i = 1'b1; we_n_i = 1'b1; addr_i = 11'h5a6;
    repeat (2) @(negedge clk_i);
    chk("R4 col transparent", 32'(col_addr_o), 32'h5a6);
    chk("R8 word select", 32'(word_sel_o), 32'h2);
    addr_i = 11'h3c3;
    repeat (2) @(negedge clk_i);
    chk("R4 col follows", 32'(col_addr_o), 32'h3c3);
    chk("R8 word select 2", 32'(word_sel_o), 32'h3);
    col_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    addr_i = 11'h100;
    repeat (3) @(negedge clk_i);
    chk("R4 col held", 32'(col_addr_o), 32'h3c3);
    // R7 data write strobe
    chk("R7 col low we high", 32'(data_wr_o), 0);
    we_n_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R7 col low we low", 32'(data_wr_o), 1);
    col_n_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R7 col high we low", 32'(data_wr_o), 0);
    chk("R9 idle after all", 32'(op_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule